// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Filtering

This block receives asynchronous serial characters of 5 to 9 data bits from a line sampled with a 16x oversampling enable. Each character is tagged as an address or a data character. The tag comes from the ninth data bit when the character is nine bits wide. For narrower characters it comes from the level of the first stop bit, and the sender uses two stop bits in that case.

A host-writable filter bit sets multiprocessor mode. While the bit is set, data characters are thrown away and only address characters reach the single holding register. A host that recognises its own address clears the bit and then receives every following character. It sets the bit again once its message ends.

Each accepted character updates the holding register and raises a one-cycle completion strobe. A frame-error flag travels with each accepted character.

Top module: `mpuart_rx`

## Requirements
- R1: `cfg_nbits` selects the character width. Values 5 to 9 are used as given, values below 5 act as 5 and values above 9 act as 9. Bits arrive least significant first, data bit k lands in `rx_data[k]`, and unused upper bits of `rx_data` read 0.
- R2: A start bit counts only if the line is still low on the 8th oversampling tick after the falling edge is seen. A shorter low pulse produces no character.
- R3: With a 9-bit width the ninth data bit is the frame-type bit, and it also appears in `rx_data[8]`.
- R4: With a 5 to 8 bit width the level of the first stop bit is the frame-type bit. `rx_addr` = 1 marks an address character and 0 a data character.
- R5: While `mpm` is 1, a data character raises no `rx_done` and leaves `rx_data`, `rx_addr` and `rx_ferr` unchanged.
- R6: While `mpm` is 1, address characters are delivered with `rx_done`.
- R7: While `mpm` is 0, every character is delivered.
- R8: `rx_ferr` is 1 when the final stop bit is low. That is the second stop bit for 5 to 8 bit widths and the only stop bit for 9-bit widths. The first stop bit of a narrow character is never checked.
- R9: `rx_done` lasts one cycle. `rx_data`, `rx_addr` and `rx_ferr` hold their values until the next accepted character.
- R10: A cycle with `mpm_wr` = 1 loads `mpm_wdata` into `mpm`, which is readable on the next cycle. The new value governs every character whose final stop sample comes after that cycle.
- R11: After reset, `mpm`, `rx_done`, `rx_data`, `rx_addr` and `rx_ferr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tick16 | input | 1 | one-cycle enable at 16x the bit rate |
| rx_line | input | 1 | serial input, idle high |
| cfg_nbits | input | 4 | character width, 5 to 9 |
| mpm_wr | input | 1 | write strobe for the filter bit |
| mpm_wdata | input | 1 | value written to the filter bit |
| mpm | output | 1 | current filter bit |
| rx_data | output | 9 | holding register, right aligned |
| rx_addr | output | 1 | frame type of held character, 1 = address |
| rx_ferr | output | 1 | frame error of held character |
| rx_done | output | 1 | one-cycle strobe per accepted character |

## Verification
Two events can fall in the same cycle: a host write to the filter bit and the acceptance decision made at a character's final stop sample. The bench provokes this by writing the bit while the final stop bit is on the line, before its mid-bit sample. In that case the written value must decide whether that character is kept or dropped. The bench also writes the bit after completion, and then the character already delivered must be untouched. A scoreboard built from the written value judges each case by whether a completion strobe appears and by what the holding register contains.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  localparam int DATA_MAX = 9;
  localparam int DATA_MIN = 5;
  localparam int NB_W     = $clog2(DATA_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [DATA_MAX-1:0] data;
    logic                addr;
    logic                ferr;
  } rx_frame_t;
endpackage

// File: rtl/mpuart_timer.sv
module mpuart_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic mid_hit,
  output logic bit_hit
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign mid_hit = tick && (cnt_q == MID);
  assign bit_hit = tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (bit_hit) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mpuart_fsm.sv
module mpuart_fsm
  import mpuart_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rxd,
  input  logic [NB_W-1:0] cfg_nbits,
  input  logic            mid_hit,
  input  logic            bit_hit,
  output logic            tclr,
  output logic            fin,
  output rx_frame_t       frame
);
  rx_state_e              st_q, st_d;
  logic [NB_W-1:0]        idx_q, idx_d, nb_q, nb_d;
  logic [DATA_MAX-1:0]    sh_q, sh_d;
  logic                   s1_q, s1_d, ferr_q, ferr_d, fin_d;

  function automatic logic [NB_W-1:0] clamp_nb(input logic [NB_W-1:0] v);
    if (v < NB_W'(DATA_MIN))      return NB_W'(DATA_MIN);
    else if (v > NB_W'(DATA_MAX)) return NB_W'(DATA_MAX);
    else                          return v;
  endfunction

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    nb_d   = nb_q;
    sh_d   = sh_q;
    s1_d   = s1_q;
    ferr_d = ferr_q;
    fin_d  = 1'b0;
    tclr   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        tclr = 1'b1;
        if (tick && !rxd) st_d = ST_START;
      end
      ST_START: begin
        if (mid_hit) begin
          tclr = 1'b1;
          if (rxd) st_d = ST_IDLE;
          else begin
            st_d  = ST_DATA;
            idx_d = '0;
            nb_d  = clamp_nb(cfg_nbits);
            sh_d  = '0;
          end
        end
      end
      ST_DATA: begin
        if (bit_hit) begin
          sh_d[idx_q] = rxd;
          if (idx_q == nb_q - 1'b1)
            st_d = (nb_q == NB_W'(DATA_MAX)) ? ST_STOP2 : ST_STOP1;
          else
            idx_d = idx_q + 1'b1;
        end
      end
      ST_STOP1: begin
        if (bit_hit) begin
          s1_d = rxd;
          st_d = ST_STOP2;
        end
      end
      ST_STOP2: begin
        if (bit_hit) begin
          fin_d  = 1'b1;
          ferr_d = !rxd;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      nb_q   <= NB_W'(DATA_MAX);
      sh_q   <= '0;
      s1_q   <= 1'b0;
      ferr_q <= 1'b0;
      fin    <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      nb_q   <= nb_d;
      sh_q   <= sh_d;
      s1_q   <= s1_d;
      ferr_q <= ferr_d;
      fin    <= fin_d;
    end
  end

  assign frame.data = sh_q;
  assign frame.addr = (nb_q == NB_W'(DATA_MAX)) ? sh_q[DATA_MAX-1] : s1_q;
  assign frame.ferr = ferr_q;

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((frame.data >> nb_q) == '0)); // R1
  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin); // R9
endmodule

// File: rtl/mpuart_filter.sv
module mpuart_filter
  import mpuart_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fin,
  input  rx_frame_t           frame,
  input  logic                mpm_wr,
  input  logic                mpm_wdata,
  output logic                mpm,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_addr,
  output logic                rx_ferr,
  output logic                rx_done
);
  logic      mpm_d, acc;
  rx_frame_t hold_q, hold_d;

  always_comb begin
    mpm_d  = mpm_wr ? mpm_wdata : mpm;
    acc    = fin && (!mpm || frame.addr);
    hold_d = acc ? frame : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpm     <= 1'b0;
      hold_q  <= '0;
      rx_done <= 1'b0;
    end else begin
      mpm     <= mpm_d;
      hold_q  <= hold_d;
      rx_done <= acc;
    end
  end

  assign rx_data = hold_q.data;
  assign rx_addr = hold_q.addr;
  assign rx_ferr = hold_q.ferr;

  AST_DATA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && mpm && !frame.addr) |=> (!rx_done && $stable(rx_data))); // R5
  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && frame.addr) |=> rx_done); // R6
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !mpm) |=> rx_done); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(rx_data) && $stable(rx_addr) && $stable(rx_ferr))); // R9
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mpm_wr |=> (mpm == $past(mpm_wdata))); // R10
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic                rx_line,
  input  logic [NB_W-1:0]     cfg_nbits,
  input  logic                mpm_wr,
  input  logic                mpm_wdata,
  output logic                mpm,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_addr,
  output logic                rx_ferr,
  output logic                rx_done
);
  logic [1:0] sync_q;
  logic       rxd, mid_hit, bit_hit, tclr, fin;
  rx_frame_t  frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_line};
  end
  assign rxd = sync_q[1];

  mpuart_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .clr(tclr),
    .mid_hit(mid_hit), .bit_hit(bit_hit)
  );

  mpuart_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
    .cfg_nbits(cfg_nbits), .mid_hit(mid_hit), .bit_hit(bit_hit),
    .tclr(tclr), .fin(fin), .frame(frame)
  );

  mpuart_filter u_filter (
    .clk(clk), .rst_n(rst_n), .fin(fin), .frame(frame),
    .mpm_wr(mpm_wr), .mpm_wdata(mpm_wdata), .mpm(mpm),
    .rx_data(rx_data), .rx_addr(rx_addr), .rx_ferr(rx_ferr),
    .rx_done(rx_done)
  );
endmodule

// File: tb/tb_mpuart_rx.sv
module tb_mpuart_rx;
  localparam int TK  = 4;
  localparam int BIT = 16 * TK;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_line = 1'b1;
  logic [3:0] cfg_nbits = 4'd8;
  logic       mpm_wr = 1'b0;
  logic       mpm_wdata = 1'b0;
  logic       mpm;
  logic [8:0] rx_data;
  logic       rx_addr, rx_ferr, rx_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic       mode_m = 1'b0;
  logic [8:0] last_data = '0;
  logic [10:0] expq[$];
  logic       prev_done = 1'b0;

  always #5 clk = ~clk;

  mpuart_rx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .cfg_nbits(cfg_nbits), .mpm_wr(mpm_wr), .mpm_wdata(mpm_wdata),
    .mpm(mpm), .rx_data(rx_data), .rx_addr(rx_addr), .rx_ferr(rx_ferr),
    .rx_done(rx_done)
  );

  begin : g_tick
    int tc = 0;
    always @(negedge clk) begin
      tc <= (tc == TK - 1) ? 0 : tc + 1;
      tick16 <= (tc == TK - 1);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items on each completion strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check("R9 strobe one cycle", {31'd0, rx_done}, 32'd0);
      if (rx_done) begin
        if (expq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5/R2 unexpected character actual=%0h expected=none",
                   {rx_addr, rx_ferr, rx_data});
        end else begin
          logic [10:0] e;
          e = expq.pop_front();
          check("R1/R3/R4/R8 delivered character",
                {21'd0, rx_addr, rx_ferr, rx_data}, {21'd0, e});
        end
        last_data = rx_data;
      end
    end
    prev_done <= rx_done && rst_n;
  end

  task automatic bit_out(input logic v);
    rx_line = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic write_mode(input logic v);
    mpm_wdata = v; mpm_wr = 1'b1;
    @(negedge clk);
    mpm_wr = 1'b0;
    mode_m = v;
  endtask

  // driver: pushes the expected item, then sends the character
  // wr < 0: no write; otherwise write wr[0] early in the final stop bit (R10)
  task automatic send(input int nbc, input logic [8:0] d, input logic typ,
                      input logic s2, input int wr);
    int n;
    logic ft, mode_eff;
    logic [8:0] dm;
    n = (nbc < 5) ? 5 : ((nbc > 9) ? 9 : nbc);
    dm = d & ((9'h1 << n) - 9'h1);
    ft = (n == 9) ? d[8] : typ;
    mode_eff = (wr >= 0) ? wr[0] : mode_m;
    if (!mode_eff || ft) expq.push_back({ft, !s2, dm});
    cfg_nbits = 4'(nbc);
    bit_out(1'b0);
    for (int i = 0; i < n; i++) bit_out(d[i]);
    if (n < 9) bit_out(typ);
    if (wr >= 0) begin
      rx_line = s2;
      repeat (2 * TK) @(negedge clk);
      write_mode(wr[0]);
      repeat (BIT - 2 * TK - 1) @(negedge clk);
    end else bit_out(s2);
    bit_out(1'b1);
    bit_out(1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {27'd0, mpm, rx_done, rx_addr, rx_ferr, 1'b0}, 32'd0);
    check("R11 reset data", {23'd0, rx_data}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R7 open mode, R4 type from first stop bit
    send(8, 9'h0A5, 1'b0, 1'b1, -1);
    send(8, 9'h03C, 1'b1, 1'b1, -1);
    // R1 widths and masking
    send(5, 9'h1FF, 1'b0, 1'b1, -1);
    send(6, 9'h02A, 1'b1, 1'b1, -1);
    send(7, 9'h055, 1'b0, 1'b1, -1);
    // R3 nine-bit frame type
    send(9, 9'h1A5, 1'b0, 1'b1, -1);
    send(9, 9'h0C3, 1'b0, 1'b1, -1);
    // R8 final stop low flags error; low first stop alone does not
    send(8, 9'h0F0, 1'b1, 1'b0, -1);
    send(9, 9'h011, 1'b0, 1'b0, -1);
    // R1 out-of-range width codes
    send(3, 9'h1EB, 1'b0, 1'b1, -1);
    send(12, 9'h155, 1'b0, 1'b1, -1);
    // R2 short low pulse is not a start bit
    rx_line = 1'b0;
    repeat (3 * TK) @(negedge clk);
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    check("R2 glitch leaves data", {23'd0, rx_data}, {23'd0, last_data});

    // R10 readback
    write_mode(1'b1);
    check("R10 mode readback", {31'd0, mpm}, 32'd1);
    // R5 data dropped, R6 address passes
    send(8, 9'h077, 1'b0, 1'b1, -1);
    check("R5 data held after drop", {23'd0, rx_data}, {23'd0, last_data});
    send(8, 9'h012, 1'b1, 1'b1, -1);
    send(9, 9'h077, 1'b0, 1'b1, -1);
    check("R5 nine-bit drop", {23'd0, rx_data}, 32'h012);
    send(9, 9'h144, 1'b0, 1'b1, -1);
    // R10 write during final stop bit applies to that character
    send(8, 9'h066, 1'b0, 1'b1, 0);
    check("R10 mode cleared", {31'd0, mpm}, 32'd0);
    send(8, 9'h099, 1'b0, 1'b1, 1);
    check("R10 late-set drop", {23'd0, rx_data}, 32'h066);
    // R10 write after completion does not touch delivered character
    write_mode(1'b0);
    check("R10 held after late write", {23'd0, rx_data}, 32'h066);
    send(7, 9'h033, 1'b0, 1'b1, -1);

    repeat (4 * BIT) @(negedge clk);
    check("R5 no pending expected", expq.size(), 32'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule